// File: doc/BRIEF.md
# Benes Permutation Fabric

This block is an N-port rearrangeable permutation network built from 2x2 exchange elements arranged in the recursive Benes pattern. An outer column of elements splits traffic between an upper and a lower half-size network, each built the same way down to a single central column, and a mirrored outer column recombines them. For the default N=8 this gives 5 columns of 4 elements each. Any permutation of input words to output ports can be reached with the right set of element states.

Each cycle the block takes N data words and one flat control vector holding one bit per element. It moves the words to the outputs as those bits direct. The control bits are computed elsewhere. A parameter mask chooses which columns end in a register stage. The control bits for each column are delayed inside the block to match, so the words and the controls presented in the same cycle always travel together.

Top module: `benes_fabric`

## Requirements
- R1: Element e of column c owns stage positions 2e and 2e+1 and reads control bit ctrl_i[c*(N/2)+e]; 0 passes both words straight, 1 swaps them. When only an element of the first or last column is set, output ports 2e and 2e+1 swap and every other port carries its own input.
- R2: With every control bit at 0, output port j carries input word j for every j.
- R3: With every control bit at 1, output port j carries input word j XOR N/2 (the top index bit inverted).
- R4: After column c, for c below log2(N)-1, a word at local position q of its block of size B=N>>c moves to local position (q mod 2)*B/2 + q/2. After column c, for c from log2(N)-1 up to the second-last column, a word moves from local position q of a block of size B=N>>(2*log2(N)-3-c) to position 2*(q mod B/2) + q/(B/2).
- R5: For any control vector, the outputs are a permutation of the inputs: each input word appears on exactly one output port.
- R6: The latency equals the number of set bits in the low 2*log2(N)-1 bits of REG_MASK, 5 cycles by default. The output shows a word in exactly that cycle and not one cycle earlier.
- R7: A word set and a control vector presented in the same cycle are routed together. Changing the control every cycle gives each word set its own routing.
- R8: While rst_ni is low, every register stage clears at once, so with the last column registered all output words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the column register stages |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N*W | Input words; word j at bits [j*W +: W] |
| ctrl_i | input | (2*log2(N)-1)*N/2 | Element controls, column-major; 0 straight, 1 swap |
| data_o | output | N*W | Output words; port j at bits [j*W +: W] |

## Verification
A wrong element state or a miswired link between columns shows up as a word on the wrong output port. It appears in the same cycle in which that word set reaches the outputs, so it is seen one latency after the stimulus. A control delay that is off by one cycle routes a word set with its neighbour's controls, and back-to-back streams of distinct controls show this at once. A missed or duplicated word breaks the XOR signature of the column, and the check fires at the clock edge where the faulty column is sampled.

// File: rtl/benes_pkg.sv
package benes_pkg;

  // position in the next column fed by output position pos of column col
  function automatic int unsigned link_dst(int unsigned col, int unsigned pos,
                                           int unsigned n_ports, int unsigned log_n);
    int unsigned blk, base, q, half;
    if (col < log_n - 1) blk = n_ports >> col;
    else                 blk = n_ports >> (2 * log_n - 3 - col);
    half = blk / 2;
    base = (pos / blk) * blk;
    q    = pos - base;
    if (col < log_n - 1) return base + (q % 2) * half + q / 2;   // split to halves
    return base + (q % half) * 2 + q / half;                      // merge halves
  endfunction

  // number of registered columns strictly below column upto
  function automatic int unsigned count_regs(logic [31:0] mask, int unsigned upto);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < upto; i++) n += int'(mask[i]);
    return n;
  endfunction

endpackage

// File: rtl/benes_xchg.sv
module benes_xchg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  assign a_o = sel_i ? b_i : a_i;
  assign b_o = sel_i ? a_i : b_i;
endmodule

// File: rtl/benes_column.sv
module benes_column #(
  parameter int unsigned N   = 8,
  parameter int unsigned W   = 16,
  parameter bit          REG = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0][W-1:0]   data_i,
  input  logic [N/2-1:0]        sel_i,
  output logic [N-1:0][W-1:0]   data_o
);
  localparam int unsigned H = N / 2;

  logic [N-1:0][W-1:0] mix;

  for (genvar e = 0; e < H; e++) begin : g_elem
    benes_xchg #(.W(W)) u_xchg (
      .a_i  (data_i[2*e]),
      .b_i  (data_i[2*e+1]),
      .sel_i(sel_i[e]),
      .a_o  (mix[2*e]),
      .b_o  (mix[2*e+1])
    );
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o <= '0;
      else         data_o <= mix;
    end
  end else begin : g_comb
    assign data_o = mix;
  end

  logic [W-1:0] in_x, mix_x;
  always_comb begin
    in_x  = '0;
    mix_x = '0;
    for (int i = 0; i < N; i++) begin
      in_x  = in_x ^ data_i[i];
      mix_x = mix_x ^ mix[i];
    end
  end

  p_bar_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> (mix == data_i));

  p_xor_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_x == in_x);

endmodule

// File: rtl/benes_link.sv
module benes_link #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 16,
  parameter int unsigned LOGN = 3,
  parameter int unsigned COL  = 0
) (
  input  logic [N-1:0][W-1:0] data_i,
  output logic [N-1:0][W-1:0] data_o
);
  for (genvar p = 0; p < N; p++) begin : g_wire
    localparam int unsigned DST = benes_pkg::link_dst(COL, p, N, LOGN);
    assign data_o[DST] = data_i[p];
  end
endmodule

// File: rtl/benes_ctrl_delay.sv
module benes_ctrl_delay #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/benes_fabric.sv
module benes_fabric #(
  parameter int unsigned N        = 8,
  parameter int unsigned W        = 16,
  parameter logic [31:0] REG_MASK = 32'hFFFF_FFFF,
  localparam int unsigned LOGN    = $clog2(N),
  localparam int unsigned COLS    = 2 * LOGN - 1,
  localparam int unsigned H       = N / 2,
  localparam int unsigned CW      = COLS * H
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N*W-1:0] data_i,
  input  logic [CW-1:0]  ctrl_i,
  output logic [N*W-1:0] data_o
);
  localparam int unsigned LAT = benes_pkg::count_regs(REG_MASK, COLS);

  logic [COLS:0][N-1:0][W-1:0]   st_d;
  logic [COLS-1:0][N-1:0][W-1:0] co_d;
  logic [COLS-1:0][H-1:0]        col_sel;

  assign st_d[0] = data_i;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int unsigned DLY = benes_pkg::count_regs(REG_MASK, c);

    if (DLY == 0) begin : g_nodly
      assign col_sel[c] = ctrl_i[c*H +: H];
    end else begin : g_dly
      benes_ctrl_delay #(.WIDTH(H), .DEPTH(DLY)) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ctrl_i[c*H +: H]),
        .q_o   (col_sel[c])
      );
    end

    benes_column #(.N(N), .W(W), .REG(REG_MASK[c])) u_col (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .data_i(st_d[c]),
      .sel_i (col_sel[c]),
      .data_o(co_d[c])
    );

    if (c < COLS - 1) begin : g_link
      benes_link #(.N(N), .W(W), .LOGN(LOGN), .COL(c)) u_link (
        .data_i(co_d[c]),
        .data_o(st_d[c+1])
      );
    end else begin : g_last
      assign st_d[c+1] = co_d[c];
    end
  end

  assign data_o = st_d[COLS];

  // XOR signature of a word set must arrive exactly LAT cycles later
  logic [W-1:0] sig_in, sig_out;
  always_comb begin
    sig_in  = '0;
    sig_out = '0;
    for (int i = 0; i < int'(N); i++) begin
      sig_in  = sig_in ^ st_d[0][i];
      sig_out = sig_out ^ st_d[COLS][i];
    end
  end

  if (LAT == 0) begin : g_sig_comb
    p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_out == sig_in);
  end else begin : g_sig_pipe
    logic [LAT-1:0][W-1:0] sig_q;
    logic [LAT-1:0]        live_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sig_q  <= '0;
        live_q <= '0;
      end else begin
        sig_q[0]  <= sig_in;
        live_q[0] <= 1'b1;
        for (int i = 1; i < int'(LAT); i++) begin
          sig_q[i]  <= sig_q[i-1];
          live_q[i] <= live_q[i-1];
        end
      end
    end
    p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q[LAT-1] |-> (sig_out == sig_q[LAT-1]));
  end

  if (REG_MASK[COLS-1]) begin : g_rst_chk
    p_reset_clear_r8: assert property (@(posedge clk_i)
      !rst_ni |-> (data_o == '0));
  end

endmodule

// File: tb/tb_benes_fabric.sv
module tb_benes_fabric;
  localparam int N    = 8;
  localparam int W    = 16;
  localparam int LOGN = 3;
  localparam int COLS = 2 * LOGN - 1;
  localparam int H    = N / 2;
  localparam int CW   = COLS * H;
  localparam int LAT  = 5;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [N*W-1:0] data_i;
  logic [CW-1:0]  ctrl_i;
  logic [N*W-1:0] data_o;

  int checks = 0;
  int failures = 0;

  benes_fabric #(.N(N), .W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .ctrl_i(ctrl_i), .data_o(data_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // independent model: where input position p ends up
  function automatic int dest_of(int p, logic [CW-1:0] ctl);
    int k, low, m;
    for (int c = 0; c < COLS; c++) begin
      if (ctl[c*H + p/2]) p = p ^ 1;
      if (c < COLS - 1) begin
        k   = (c < LOGN - 1) ? (LOGN - c) : (c - LOGN + 3);
        m   = (1 << k) - 1;
        low = p & m;
        if (c < LOGN - 1) low = (low >> 1) | ((low & 1) << (k - 1));
        else              low = ((low << 1) & m) | (low >> (k - 1));
        p = (p & ~m) | low;
      end
    end
    return p;
  endfunction

  function automatic logic [N*W-1:0] route(logic [N*W-1:0] d, logic [CW-1:0] ctl);
    logic [N*W-1:0] r;
    r = '0;
    for (int p = 0; p < N; p++) r[dest_of(p, ctl)*W +: W] = d[p*W +: W];
    return r;
  endfunction

  function automatic logic [N*W-1:0] rand_words();
    logic [N*W-1:0] r;
    for (int j = 0; j < N; j++) r[j*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic logic [CW-1:0] rand_ctrl();
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[i] = 1'($urandom);
    return r;
  endfunction

  // apply one set and sample after the pipeline has filled
  task automatic run_one(logic [N*W-1:0] d, logic [CW-1:0] ctl, output logic [N*W-1:0] q);
    @(negedge clk_i);
    data_i = d;
    ctrl_i = ctl;
    repeat (LAT) @(negedge clk_i);
    q = data_o;
  endtask

  task automatic t_reset();
    data_i = rand_words();
    ctrl_i = rand_ctrl();
    repeat (3) @(negedge clk_i);
    chk("R8 reset clear", data_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (LAT + 2) @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #1 chk("R8 async clear mid-run", data_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_identity();
    logic [N*W-1:0] d, q;
    for (int n = 0; n < 3; n++) begin
      d = rand_words();
      run_one(d, '0, q);
      chk("R2 all straight", q, d);
    end
  endtask

  task automatic t_all_cross();
    logic [N*W-1:0] d, q, e;
    for (int n = 0; n < 3; n++) begin
      d = rand_words();
      for (int j = 0; j < N; j++) e[j*W +: W] = d[(j ^ (N/2))*W +: W];
      run_one(d, '1, q);
      chk("R3 all swapped", q, e);
    end
  endtask

  task automatic t_single();
    logic [N*W-1:0] d, q, e;
    logic [CW-1:0] ctl;
    for (int i = 0; i < CW; i++) begin
      d = rand_words();
      ctl = '0;
      ctl[i] = 1'b1;
      run_one(d, ctl, q);
      if (i < H || i >= CW - H) begin
        e = d;
        e[(2*(i%H))*W +: W]   = d[(2*(i%H)+1)*W +: W];
        e[(2*(i%H)+1)*W +: W] = d[(2*(i%H))*W +: W];
        chk("R1 outer element swap", q, e);
      end else begin
        chk("R4 inner element path", q, route(d, ctl));
      end
    end
  endtask

  task automatic t_random();
    logic [N*W-1:0] d, q;
    logic [CW-1:0] ctl;
    for (int n = 0; n < 30; n++) begin
      d = rand_words();
      ctl = rand_ctrl();
      run_one(d, ctl, q);
      chk("R4 random wiring", q, route(d, ctl));
    end
  endtask

  task automatic t_bijective();
    logic [N*W-1:0] d, q;
    logic [N-1:0] seen;
    int bad;
    for (int n = 0; n < 10; n++) begin
      for (int j = 0; j < N; j++) d[j*W +: W] = W'(16'hC000 + j);
      run_one(d, rand_ctrl(), q);
      seen = '0;
      bad  = 0;
      for (int j = 0; j < N; j++) begin
        int t;
        t = int'(q[j*W +: W]) - 16'hC000;
        if (t < 0 || t >= N || seen[t]) bad++;
        else seen[t] = 1'b1;
      end
      checks++;
      if (bad != 0 || seen != '1) begin
        failures++;
        $display("FAIL R5 permutation act=%h exp=%h", seen, {N{1'b1}});
      end
    end
  endtask

  task automatic t_latency();
    logic [N*W-1:0] d, z;
    logic [CW-1:0] ctl;
    z = '0;
    run_one(z, '0, d);
    d = rand_words();
    ctl = rand_ctrl();
    @(negedge clk_i);
    data_i = d;
    ctrl_i = ctl;
    @(negedge clk_i);
    data_i = '0;
    ctrl_i = '0;
    repeat (LAT - 2) @(negedge clk_i);
    chk("R6 not one cycle early", data_o, '0);
    @(negedge clk_i);
    chk("R6 exact latency", data_o, route(d, ctl));
    @(negedge clk_i);
    chk("R6 single cycle only", data_o, '0);
  endtask

  task automatic t_stream();
    localparam int M = 16;
    logic [N*W-1:0] ds [M];
    logic [CW-1:0]  cs [M];
    for (int k = 0; k < M; k++) begin
      ds[k] = rand_words();
      cs[k] = rand_ctrl();
    end
    @(negedge clk_i);
    for (int k = 0; k < M + LAT; k++) begin
      if (k >= LAT) chk("R7 stream alignment", data_o, route(ds[k-LAT], cs[k-LAT]));
      if (k < M) begin
        data_i = ds[k];
        ctrl_i = cs[k];
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    rst_ni = 1'b1;
    data_i = '0;
    ctrl_i = '0;
    #5 rst_ni = 1'b0;
    t_reset();
    t_identity();
    t_all_cross();
    t_single();
    t_random();
    t_bijective();
    t_latency();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule